// File: doc/BRIEF.md
# Reconfigurable Two-Stage Block Interleaver

This block reorders a stream of coded bits in fixed-size blocks, so that a burst of channel errors is spread across many constellation symbols and many bit positions. It can also undo that reordering. The permutation has two stages. The first stage is a column/row transpose over 16 columns. The second stage rotates bits inside groups of `s` positions, where `s` is half the number of bits carried by one subcarrier. The block size and `s` both follow a modulation code that can change from one block to the next.

Two internal bit banks are used as a ping-pong pair. Incoming bits are written into one bank while the previous block is read out of the other bank. The bank roles swap as soon as the last bit of a block has been written. In interleave mode each bit is written at its permuted address and the bank is read back in order. In de-interleave mode the bank is written in order and read at the permuted address.

Output is paced by the input. Every accepted input bit that arrives while an older block is still waiting releases one output bit on the next cycle. The first output therefore appears exactly one block of input after the first input bit. All floor and modulo terms are produced by small counters, so the block contains no divider.

Top module: `blk_interleaver`

## Requirements
- R1: After reset `outValid` is 0. It stays 0 until the bits of the first complete block have been accepted.
- R2: The block length follows `modSel`, sampled at the first bit of the block: 0 gives 48 bits, 1 gives 96 bits, 2 gives 192 bits and 3 gives 288 bits.
- R3: When `deint` is 0, input bit number k of a block becomes output bit number j(k). With N the block length and s the group size: m = (N/16)·(k mod 16) + floor(k/16), and j = s·floor(m/s) + ((m + N − floor(16·m/N)) mod s).
- R4: When `deint` is 1, output bit number p of a block is input bit number j(p) of that block. This undoes the mapping of R3.
- R5: The group size s is 1 for `modSel` 0 and 1, 2 for `modSel` 2, and 3 for `modSel` 3.
- R6: The banks swap when the last bit of a block is accepted. Each of the following accepted bits releases the next bit of that block, with `outValid` high exactly one cycle after the accepting edge.
- R7: A cycle with `inValid` low produces no output bit on the next cycle and does not advance either block.
- R8: Changes of `modSel` or `deint` after the first bit of a block have no effect on that block's length, its permutation or its direction.
- R9: If a new block is shorter than the block being read out, the unread tail of the older block is dropped at the swap. If the new block is longer, output stops once the older block has been fully emitted, and resumes after the next swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The input bit is valid in this cycle |
| inBit | input | 1 | Coded input bit |
| modSel | input | 2 | Modulation code: 0 = BPSK, 1 = QPSK, 2 = 16-QAM, 3 = 64-QAM |
| deint | input | 1 | 0 = interleave, 1 = de-interleave |
| outValid | output | 1 | The output bit is valid in this cycle |
| outBit | output | 1 | Reordered output bit |

## Verification
The bench builds the block with its defaults: 16 columns and 48 bits per modulation unit. This gives 288-bit blocks for the largest code, and every modulation code with both group sizes 2 and 3 can be reached in a few thousand cycles. The stimulus runs a block at each modulation code in both directions, and feeds the input with random gaps. It also toggles the configuration in the middle of a block, and moves from long to short blocks and from short to long blocks, so that both the tail-drop case and the output-stall case occur.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'd0,
    MOD_QPSK  = 2'd1,
    MOD_QAM16 = 2'd2,
    MOD_QAM64 = 2'd3
  } modSel_e;

  // configuration captured at the first bit of each block
  typedef struct packed {
    modSel_e modSel;
    logic    deint;
  } blkCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic wrBank;
  } memStrobe_t;

  function automatic int unsigned bitsPerCarrier(modSel_e m);
    case (m)
      MOD_BPSK:  return 1;
      MOD_QPSK:  return 2;
      MOD_QAM16: return 4;
      default:   return 6;
    endcase
  endfunction

  function automatic int unsigned spreadOf(modSel_e m);
    if (m == MOD_BPSK) return 1;
    return bitsPerCarrier(m) / 2;
  endfunction

endpackage

// File: rtl/ilv_perm_gen.sv
module ilv_perm_gen
  import ilv_pkg::*;
#(
  parameter int COLS     = 16,
  parameter int SUB_BITS = 48,
  parameter int AW       = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          restart,
  input  logic          step,
  input  modSel_e       modSel,
  output logic [AW-1:0] seqIdx,
  output logic [AW-1:0] permIdx,
  output logic          lastIdx
);

  localparam int MAX_BPC   = 6;
  localparam int UNIT_ROWS = SUB_BITS / COLS;
  localparam int MAX_ROWS  = UNIT_ROWS * MAX_BPC;
  localparam int RW        = $clog2(MAX_ROWS + 1);
  localparam int CW        = $clog2(COLS);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] mIdx;
  logic [AW-1:0] kIdx;
  logic [1:0]    rowMod;
  logic [1:0]    colMod;
  logic [1:0]    spread;
  logic [1:0]    adj;
  logic [RW-1:0] rowsPerCol;
  logic [AW:0]   blockLen;

  always_comb begin
    rowsPerCol = RW'(UNIT_ROWS * bitsPerCarrier(modSel));
    spread     = 2'(spreadOf(modSel));
    blockLen   = (AW+1)'(SUB_BITS * bitsPerCarrier(modSel));
  end

  // The column index equals floor(16*m/N), and m mod s equals row mod s,
  // so the second stage needs only two tiny modulo counters.
  always_comb begin
    if (rowMod >= colMod) adj = rowMod - colMod;
    else                  adj = rowMod + spread - colMod;
  end

  assign lastIdx = (col == CW'(COLS - 1)) && (row == rowsPerCol - 1'b1);
  assign seqIdx  = kIdx;
  assign permIdx = mIdx - AW'(rowMod) + AW'(adj);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      col    <= '0;
      row    <= '0;
      mIdx   <= '0;
      kIdx   <= '0;
      rowMod <= '0;
      colMod <= '0;
    end else if (restart || (step && lastIdx)) begin
      col    <= '0;
      row    <= '0;
      mIdx   <= '0;
      kIdx   <= '0;
      rowMod <= '0;
      colMod <= '0;
    end else if (step) begin
      kIdx <= kIdx + 1'b1;
      if (col == CW'(COLS - 1)) begin
        col    <= '0;
        colMod <= '0;
        row    <= row + 1'b1;
        mIdx   <= AW'(row) + 1'b1;
        rowMod <= (rowMod + 2'd1 == spread) ? 2'd0 : rowMod + 2'd1;
      end else begin
        col    <= col + 1'b1;
        colMod <= (colMod + 2'd1 == spread) ? 2'd0 : colMod + 2'd1;
        mIdx   <= mIdx + AW'(rowsPerCol);
      end
    end
  end

  // R3: the permuted address never leaves the current block
  a_r3_perm_in_block: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, permIdx} < blockLen));

  // R5: the first bit of every block maps to address zero
  a_r5_head_zero: assert property (@(posedge clk) disable iff (!rstN)
    (seqIdx == '0) |-> (permIdx == '0));

  // R2: the index returns to zero after the last bit of a block
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (step && lastIdx && !restart) |=> (seqIdx == '0));

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int COLS     = 16,
  parameter int SUB_BITS = 48,
  parameter int AW       = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  modSel_e       modSel,
  input  logic          deint,
  output memStrobe_t    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  logic          bankSel;
  logic          rdPend;
  blkCfg_t       wrCfg;
  blkCfg_t       rdCfg;
  blkCfg_t       effCfg;
  logic [AW-1:0] wrSeq, wrPerm, rdSeq, rdPerm;
  logic          wrLast, rdLast;
  logic          wrStart;
  logic          swap;
  logic          rdFire;

  assign wrStart = (wrSeq == '0);

  always_comb begin
    if (wrStart) begin
      effCfg.modSel = modSel;
      effCfg.deint  = deint;
    end else begin
      effCfg = wrCfg;
    end
  end

  assign swap   = inValid && wrLast;
  assign rdFire = inValid && rdPend;

  assign strobe.wrEn   = inValid;
  assign strobe.rdEn   = rdFire;
  assign strobe.wrBank = bankSel;

  assign wrAddr = effCfg.deint ? wrSeq : wrPerm;
  assign rdAddr = rdCfg.deint ? rdPerm : rdSeq;

  ilv_perm_gen #(.COLS(COLS), .SUB_BITS(SUB_BITS), .AW(AW)) uWrGen (
    .clk     (clk),
    .rstN    (rstN),
    .restart (1'b0),
    .step    (inValid),
    .modSel  (effCfg.modSel),
    .seqIdx  (wrSeq),
    .permIdx (wrPerm),
    .lastIdx (wrLast)
  );

  ilv_perm_gen #(.COLS(COLS), .SUB_BITS(SUB_BITS), .AW(AW)) uRdGen (
    .clk     (clk),
    .rstN    (rstN),
    .restart (swap),
    .step    (rdFire),
    .modSel  (rdCfg.modSel),
    .seqIdx  (rdSeq),
    .permIdx (rdPerm),
    .lastIdx (rdLast)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= 1'b1;
      rdPend  <= 1'b0;
      wrCfg   <= '0;
      rdCfg   <= '0;
    end else begin
      if (inValid && wrStart) wrCfg <= effCfg;
      if (swap) begin
        bankSel <= ~bankSel;
        rdPend  <= 1'b1;
        rdCfg   <= effCfg;
      end else if (rdFire && rdLast) begin
        rdPend  <= 1'b0;
      end
    end
  end

  // R6: a completed block becomes readable from its first bit
  a_r6_swap_arms_read: assert property (@(posedge clk) disable iff (!rstN)
    swap |=> (rdPend && rdSeq == '0 && bankSel != $past(bankSel)));

  // R9: an idle read side sits at index zero
  a_r9_idle_read_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rdPend |-> (rdSeq == '0));

  // R8: configuration is frozen inside a block
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStart) |=> $stable(wrCfg));

endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  memStrobe_t    strobe,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic          inBit,
  output logic          outValid,
  output logic          outBit
);

  localparam int DEPTH = 1 << AW;

  logic [1:0] rdData;

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [DEPTH-1:0] store;
    always_ff @(posedge clk) begin
      if (strobe.wrEn && strobe.wrBank == 1'(b)) store[wrAddr] <= inBit;
    end
    assign rdData[b] = store[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= strobe.rdEn;
      if (strobe.rdEn) outBit <= rdData[~strobe.wrBank];
    end
  end

  // R7: every output bit was released by an accepted input bit
  a_r7_out_needs_beat: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.wrEn));

endmodule

// File: rtl/blk_interleaver.sv
module blk_interleaver
  import ilv_pkg::*;
#(
  parameter int COLS     = 16,
  parameter int SUB_BITS = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inBit,
  input  logic [1:0] modSel,
  input  logic       deint,
  output logic       outValid,
  output logic       outBit
);

  localparam int MAX_N = SUB_BITS * 6;
  localparam int AW    = $clog2(MAX_N);

  memStrobe_t    strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  ilv_ctrl #(.COLS(COLS), .SUB_BITS(SUB_BITS), .AW(AW)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .modSel  (modSel_e'(modSel)),
    .deint   (deint),
    .strobe  (strobe),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  ilv_datapath #(.AW(AW)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .inBit    (inBit),
    .outValid (outValid),
    .outBit   (outBit)
  );

  // R1: no output in the cycle right after reset release
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !outValid);

endmodule

// File: tb/sim_blk_interleaver.sv
module sim_blk_interleaver;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic [1:0] modSel = 2'd0;
  logic deint = 1'b0;
  logic outValid, outBit;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  blk_interleaver u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inBit(inBit),
    .modSel(modSel), .deint(deint), .outValid(outValid), .outBit(outBit)
  );

  // behavioural model state
  bit wrBuf[288];
  bit rdBuf[288];
  int wrCnt = 0, wrN = 48, wrS = 1;
  bit wrDeint = 0;
  int rdCnt = 0, rdN = 48, rdS = 1;
  bit rdDeint = 0, rdPend = 0;

  function automatic int lenOf(int m);
    case (m)
      0: return 48;
      1: return 96;
      2: return 192;
      default: return 288;
    endcase
  endfunction

  function automatic int sOf(int m);
    case (m)
      2: return 2;
      3: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int jf(int k, int n, int s);
    int m;
    m = (n / 16) * (k % 16) + k / 16;
    return s * (m / s) + ((m + n - (16 * m) / n) % s);
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, sample after the edge
  task automatic beat(bit v, bit b, int mod, bit de, string tag);
    bit expV;
    bit expB;
    @(negedge clk);
    inValid = v;
    inBit   = b;
    modSel  = 2'(mod);
    deint   = de;
    expV = 0;
    expB = 0;
    if (v) begin
      if (rdPend) begin
        expV = 1;
        expB = rdBuf[rdDeint ? jf(rdCnt, rdN, rdS) : rdCnt];
        rdCnt++;
        if (rdCnt == rdN) rdPend = 0;
      end
      if (wrCnt == 0) begin
        wrN = lenOf(mod);
        wrS = sOf(mod);
        wrDeint = de;
      end
      wrBuf[wrDeint ? wrCnt : jf(wrCnt, wrN, wrS)] = b;
      wrCnt++;
      if (wrCnt == wrN) begin
        rdBuf = wrBuf;
        rdN = wrN;
        rdS = wrS;
        rdDeint = wrDeint;
        rdCnt = 0;
        rdPend = 1;
        wrCnt = 0;
      end
    end
    @(posedge clk);
    #1;
    check(tag, int'(outValid), int'(expV), "outValid");
    if (expV) check(tag, int'(outBit), int'(expB), "outBit");
  endtask

  task automatic runBlock(int mod, bit de, int gapPct, string tag);
    int done = 0;
    while (done < lenOf(mod)) begin
      bit v;
      v = ($urandom_range(99) >= gapPct);
      beat(v, 1'($urandom), mod, de, tag);
      if (v) done++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(outValid), 0, "outValid in reset");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", int'(outValid), 0, "outValid after reset");

    runBlock(1, 0, 0, "R1");      // first QPSK block: nothing out yet
    runBlock(1, 0, 0, "R3");      // QPSK interleaved readout
    runBlock(0, 0, 0, "R9");      // 48-bit block truncates the 96-bit one
    runBlock(2, 0, 35, "R7");     // 16-QAM with gaps; older block stalls
    runBlock(3, 1, 0, "R5");      // 64-QAM written; 16-QAM interleaved out
    // R8: configuration wiggles inside a 64-QAM de-interleave block
    begin
      int done = 0;
      while (done < 288) begin
        int m;
        bit d;
        m = (done == 0) ? 3 : $urandom_range(3);
        d = (done == 0) ? 1'b1 : 1'($urandom);
        beat(1'b1, 1'($urandom), m, d, "R8");
        done++;
      end
    end
    runBlock(2, 1, 20, "R4");     // de-interleaved 288-bit readout, cut at 192
    runBlock(0, 0, 0, "R2");
    runBlock(0, 0, 0, "R6");
    runBlock(1, 1, 10, "R6");
    runBlock(3, 0, 0, "R3");
    runBlock(3, 0, 0, "R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule